// File: doc/BRIEF.md
# OTP Programming-Mode Port

This block is the device-side logic that a one-time-programmable program store runs while it is being programmed. No address bus reaches the device. An internal word address is cleared by a mode command and then moved forward by an external stepping clock, `pclk`. Four `pclk` pulses make one word cycle. The low byte of the 16-bit word travels on the first two pulses and the high byte on the last two. All of it passes over one 8-bit data port. The port is an input except in read/verify mode, when it drives.

The device enters programming mode only in one way. Its reset input must first be held long enough, and the high-voltage-present indication must then rise while that reset is still asserted. After entry, a 4-bit mode code picks one of four operations: clear the address, write, read/verify, or inhibit. The storage array is modelled as a plain synchronous memory. All inputs are sampled on the system clock `clk`. `pclk` edges are found after a two-stage synchronizer.

Top module: `otp_prog_port`

## Requirements
- R1: After `rst_n` is released, and before programming mode is entered, `d_oe` and `wrap` are 0 for every mode code.
- R2: Programming mode is entered only after two conditions are met. `dev_reset` must have stayed high for `HOLD` consecutive `clk` cycles. `hv_ok` must then be high while `dev_reset` is still high. A shorter hold does not enter the mode. Re-raising `hv_ok` after an exit does not enter the mode without a new hold.
- R3: The mode code `md[3:0]` is decoded as follows. 4'b0101 clears the address. 4'b1110 writes. 4'b1100 reads or verifies. 4'b11x1 inhibits. Any other code holds the phase and the address still, whatever `pclk` does.
- R4: The clear code resets the word address and the pulse phase to 0 and clears `wrap`.
- R5: In write, read and inhibit modes, the address increases by 1 on the third falling edge of `pclk` in each four-pulse cycle. Nothing other than `pclk` and the clear code changes it.
- R6: In write mode, `d_in` is sampled at two points. The sample at the rising edge of pulse 1 is the low byte. The sample at the rising edge of pulse 3 is the high byte. The word is stored at the current address on the falling edge of pulse 3.
- R7: `d_oe` is 1 only in read mode while programming mode is active. While pulses 1 and 2 are high, `d_out` shows the low byte of the word at the address current at the start of the cycle. While pulses 3 and 4 are high, it shows that word's high byte.
- R8: Inhibit mode steps the address like the other modes but never changes the array.
- R9: The address wraps from 2^AW-1 to 0. On that wrap, `wrap` is set, and it stays set until the next clear.
- R10: When `hv_ok` falls, programming mode ends. `d_oe` drops, and `pclk` pulses no longer move the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low logic reset |
| dev_reset | input | 1 | Device reset pin, active high, used for mode entry |
| hv_ok | input | 1 | Programming voltages present |
| pclk | input | 1 | External address stepping clock |
| md | input | 4 | Mode code, bit 0 is the first select line |
| d_in | input | 8 | Data port, input side |
| d_out | output | 8 | Data port, output side |
| d_oe | output | 1 | Data port drive enable |
| wrap | output | 1 | Address wrapped since the last clear |

## Verification
A phase counter that slips moves every later byte boundary and every address step. The read-back then shows bytes swapped or words shifted by one, starting from the first word cycle after the slip. A wrong address either lands a write in the wrong word or is missed, which the next full readback reveals. It also makes `wrap` rise one word too early or too late. Entry and exit faults appear at once on `d_oe` when the mode code is read.

// File: rtl/otp_prog_port.sv
module otp_prog_port #(
  parameter int AW   = 12,
  parameter int HOLD = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dev_reset,
  input  logic       hv_ok,
  input  logic       pclk,
  input  logic [3:0] md,
  input  logic [7:0] d_in,
  output logic [7:0] d_out,
  output logic       d_oe,
  output logic       wrap
);
  localparam int HW    = $clog2(HOLD + 1);
  localparam int DEPTH = 1 << AW;
  localparam logic [3:0] M_CLR = 4'b0101;
  localparam logic [3:0] M_WR  = 4'b1110;
  localparam logic [3:0] M_RD  = 4'b1100;

  logic [HW-1:0] hold_cnt;
  logic          active;
  logic [2:0]    ps;
  logic [1:0]    ph;
  logic [AW-1:0] addr;
  logic [7:0]    lo_q, hi_q;
  logic [15:0]   rd_word;
  logic [15:0]   mem [DEPTH];

  wire armed  = hold_cnt == HW'(HOLD);
  wire m_clr  = md == M_CLR;
  wire m_wr   = md == M_WR;
  wire m_rd   = md == M_RD;
  wire m_inh  = md[3] & md[2] & md[0];
  wire step   = active & (m_wr | m_rd | m_inh);
  wire p_rise = ps[1] & ~ps[2];
  wire p_fall = ~ps[1] & ps[2];
  wire adv    = step & p_fall & (ph == 2'd2);
  wire we     = adv & m_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps       <= '0;
      hold_cnt <= '0;
      active   <= 1'b0;
    end else begin
      ps <= {ps[1:0], pclk};
      if (dev_reset) begin
        if (!armed) hold_cnt <= hold_cnt + HW'(1);
      end else begin
        hold_cnt <= '0;
      end
      if (!hv_ok)      active <= 1'b0;
      else if (armed)  active <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= '0;
      addr <= '0;
      wrap <= 1'b0;
      lo_q <= '0;
      hi_q <= '0;
    end else if (active && m_clr) begin
      ph   <= '0;
      addr <= '0;
      wrap <= 1'b0;
    end else begin
      if (step && p_fall) ph <= ph + 2'd1;
      if (adv) begin
        addr <= addr + AW'(1);
        if (&addr) wrap <= 1'b1;
      end
      if (step && p_rise && ph == 2'd0) lo_q <= d_in;
      if (step && p_rise && ph == 2'd2) hi_q <= d_in;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= {hi_q, lo_q};
    if (ph == 2'd0) rd_word <= mem[addr];
  end

  assign d_oe  = active & m_rd;
  assign d_out = ph[1] ? rd_word[15:8] : rd_word[7:0];
endmodule

// File: rtl/otp_prog_port_chk.sv
module otp_prog_port_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          active,
  input logic          armed,
  input logic [1:0]    ph,
  input logic [AW-1:0] addr,
  input logic          adv,
  input logic          we,
  input logic          wrap,
  input logic          d_oe,
  input logic [3:0]    md
);
  // R2
  entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(armed));
  // R4
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && md == 4'b0101) |=> (addr == '0 && ph == 2'd0 && !wrap));
  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != $past(addr)) |-> ($past(adv) || $past(active && md == 4'b0101)));
  // R6
  commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (addr == AW'($past(addr) + AW'(1))));
  // R9
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrap) |-> (addr == '0));
  // R7
  drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> (active && md == 4'b1100));
  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(addr));
endmodule

bind otp_prog_port otp_prog_port_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .armed(armed), .ph(ph),
  .addr(addr), .adv(adv), .we(we), .wrap(wrap), .d_oe(d_oe), .md(md)
);

// File: tb/otp_prog_port_bench.sv
module otp_prog_port_bench;
  localparam int TCLK = 10;
  localparam int AW   = 4;
  localparam int HOLD = 5;
  localparam int N    = 1 << AW;

  logic clk = 0, rst_n = 0, dev_reset = 0, hv_ok = 0, pclk = 0;
  logic [3:0] md = 4'b0000;
  logic [7:0] d_in = '0, d_out;
  logic d_oe, wrap;
  int total = 0, bad = 0, cyc = 0;

  otp_prog_port #(.AW(AW), .HOLD(HOLD)) u_otp_prog_port (
    .clk(clk), .rst_n(rst_n), .dev_reset(dev_reset), .hv_ok(hv_ok),
    .pclk(pclk), .md(md), .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .wrap(wrap));

  always #(TCLK/2) clk = ~clk;

  function automatic logic [15:0] pat(int a);
    return 16'(a * 16'h1357) ^ 16'hA5C3;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(output logic [7:0] seen, output logic oe);
    pclk = 1; wait_n(4);
    seen = d_out; oe = d_oe;
    pclk = 0; wait_n(4);
  endtask

  task automatic write_word(logic [15:0] w);
    logic [7:0] s; logic o;
    md = 4'b1110;
    d_in = w[7:0];  pulse(s, o); pulse(s, o);
    d_in = w[15:8]; pulse(s, o); pulse(s, o);
  endtask

  task automatic read_word(string tag, logic [15:0] exp);
    logic [7:0] s; logic o;
    md = 4'b1100;
    pulse(s, o); chk({tag, " lo1"}, s, exp[7:0]); chk({tag, " oe"}, o, 1);
    pulse(s, o); chk({tag, " lo2"}, s, exp[7:0]);
    pulse(s, o); chk({tag, " hi3"}, s, exp[15:8]);
    pulse(s, o); chk({tag, " hi4"}, s, exp[15:8]);
  endtask

  task automatic quad(logic [3:0] code, logic [7:0] data);
    logic [7:0] s; logic o;
    md = code; d_in = data;
    for (int k = 0; k < 4; k++) begin
      pulse(s, o);
      chk("R7 no drive outside read", o, 0);
    end
  endtask

  task automatic clear_addr();
    md = 4'b0101; wait_n(3);
  endtask

  task automatic enter();
    dev_reset = 1; wait_n(HOLD + 2);
    hv_ok = 1; wait_n(3);
    dev_reset = 0; wait_n(2);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] s; logic o;
    wait_n(3); rst_n = 1; wait_n(2);
    md = 4'b1100; wait_n(2);
    chk("R1 reset oe", d_oe, 0);
    chk("R1 reset wrap", wrap, 0);

    dev_reset = 1; wait_n(HOLD - 2); dev_reset = 0; wait_n(2);
    hv_ok = 1; wait_n(4);
    chk("R2 short hold no entry", d_oe, 0);
    hv_ok = 0; wait_n(2);

    enter();
    chk("R2 entry read drives", d_oe, 1);
    clear_addr();
    chk("R4 clear wrap", wrap, 0);

    for (int a = 0; a < N; a++) begin
      write_word(pat(a));
      if (a == N - 2) chk("R9 no wrap before last", wrap, 0);
    end
    chk("R9 wrap set", wrap, 1);
    clear_addr();
    chk("R9 R4 wrap cleared", wrap, 0);

    for (int a = 0; a < N; a++) read_word("R6 R7 R5 readback", pat(a));

    clear_addr();
    quad(4'b1101, 8'h3C);
    read_word("R8 R5 inhibit advanced", pat(1));
    clear_addr();
    quad(4'b1111, 8'hC3);
    quad(4'b1101, 8'h5A);
    read_word("R8 inhibit kept word2", pat(2));
    clear_addr();
    read_word("R8 word0 intact", pat(0));
    read_word("R8 word1 intact", pat(1));

    clear_addr();
    quad(4'b0000, 8'h77);
    read_word("R3 other code holds", pat(0));

    md = 4'b1100; wait_n(20);
    chk("R5 no pclk no step", d_out, pat(1) & 16'hFF);

    hv_ok = 0; wait_n(3);
    chk("R10 exit oe", d_oe, 0);
    for (int k = 0; k < 4; k++) pulse(s, o);
    hv_ok = 1; wait_n(4);
    chk("R2 reraise without hold", d_oe, 0);
    hv_ok = 0; wait_n(2);
    enter();
    read_word("R10 address held across exit", pat(1));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule